// File: doc/BRIEF.md
# Multi-Cycle Program Counter Update Unit

This block owns the program counter of a multi-cycle 32-bit RISC core and decides, on each rising clock edge, whether the counter moves and where it goes. The core's controller steps through fetch, decode and execute phases. In each phase it presents a two-bit source code and two write strobes: one unconditional and one that only takes effect when the ALU reports a zero result. The counter value is driven straight out to the shared memory address selector and to the ALU operand selector.

Three next-value sources are offered. The first is the live ALU result, which is PC+4 during fetch and is written to the counter directly with no staging register. The second is the buffered ALU output register, which holds a branch target computed in decode: the sign-extended 16-bit offset, shifted left by two and added to PC+4. The third is a jump target. Its low two bits are zero, its middle bits come from the instruction's 26-bit jump field, and its top four bits come from the current counter value. Because fetch has already written PC+4 into the counter, those top bits are the upper bits of PC+4.

Top module: `pc_update_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, the counter becomes 0x00000000 at that edge, whatever the other inputs are.
- R2: The counter loads a new value only when `pc_wr` is high, or when both `pc_wr_cond` and `alu_zero` are high. When neither holds, it keeps its value.
- R3: Source code 2'b00 with the write enabled loads `alu_result`. This is the sequential-fetch path.
- R4: Source code 2'b01 with the write enabled loads `alu_out_reg`. This is the taken-branch path.
- R5: Source code 2'b10 with the write enabled loads a jump target made of bits 31..28 of the current counter, followed by `jump_field` in bits 27..2, followed by 2'b00 in bits 1..0.
- R6: Source code 2'b11 is reserved. With the write enabled it leaves the counter unchanged.
- R7: A conditional write with `alu_zero` low and `pc_wr` low is ignored, so the counter is unchanged (a not-taken branch).
- R8: With `pc_wr` high, the load happens whether `alu_zero` is high or low.
- R9: `pc` is a registered output. It stays constant between rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| alu_result | input | 32 | Live ALU result (PC+4 during fetch) |
| alu_out_reg | input | 32 | Buffered ALU output register (branch target) |
| jump_field | input | 26 | Jump immediate from the instruction register |
| alu_zero | input | 1 | ALU zero flag (operands equal) |
| pc_src | input | 2 | Next-value source code: 00 ALU, 01 buffer, 10 jump, 11 reserved |
| pc_wr | input | 1 | Unconditional write strobe |
| pc_wr_cond | input | 1 | Conditional write strobe, gated by `alu_zero` |
| pc | output | 32 | Current program counter |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge and that reset is held for at least one edge before any other checks apply. They place no restriction on combinations of strobes, so both strobes high at once and the reserved source code are both legal.

The stimulus changes inputs only on the falling edge and always drives defined values. It applies reset first. It then mixes directed controller sequences (fetch, branch taken, branch not taken, jump, reserved code) with pseudo-random strobe and source patterns, so every combination that the assertions accept is also exercised.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int XLEN_DEF  = 32;
    localparam int JBITS_DEF = 26;

    typedef enum logic [1:0] {
        SRC_ALU  = 2'b00,
        SRC_BUF  = 2'b01,
        SRC_JUMP = 2'b10,
        SRC_RSVD = 2'b11
    } pc_src_e;
endpackage

// File: rtl/pcu_jump_former.sv
module pcu_jump_former #(
    parameter int XLEN  = 32,
    parameter int JBITS = 26
) (
    input  logic [XLEN-1:0]  pc_cur,
    input  logic [JBITS-1:0] jfield,
    output logic [XLEN-1:0]  target
);
    localparam int HI = XLEN - JBITS - 2;

    // Upper bits come from the counter, which already holds PC+4 after fetch.
    always_comb begin
        target = {pc_cur[XLEN-1 -: HI], jfield, 2'b00};
    end
endmodule

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
    import pcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      src,
    input  logic [XLEN-1:0] alu_result,
    input  logic [XLEN-1:0] alu_buf,
    input  logic [XLEN-1:0] jump_tgt,
    input  logic [XLEN-1:0] pc_cur,
    output logic [XLEN-1:0] nxt
);
    pc_src_e sel;

    always_comb begin
        sel = pc_src_e'(src);
        unique case (sel)
            SRC_ALU:  nxt = alu_result;
            SRC_BUF:  nxt = alu_buf;
            SRC_JUMP: nxt = jump_tgt;
            SRC_RSVD: nxt = pc_cur;
            default:  nxt = pc_cur;
        endcase
    end
endmodule

// File: rtl/pcu_wr_gate.sv
module pcu_wr_gate (
    input  logic wr,
    input  logic wr_cond,
    input  logic zero,
    output logic en
);
    always_comb begin
        en = (zero & wr_cond) | wr;
    end
endmodule

// File: rtl/pc_update_unit.sv
module pc_update_unit
    import pcu_pkg::*;
#(
    parameter int XLEN  = XLEN_DEF,
    parameter int JBITS = JBITS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [XLEN-1:0]  alu_result,
    input  logic [XLEN-1:0]  alu_out_reg,
    input  logic [JBITS-1:0] jump_field,
    input  logic             alu_zero,
    input  logic [1:0]       pc_src,
    input  logic             pc_wr,
    input  logic             pc_wr_cond,
    output logic [XLEN-1:0]  pc
);
    logic [XLEN-1:0] jump_tgt;
    logic [XLEN-1:0] pc_next;
    logic            wr_en;

    pcu_jump_former #(.XLEN(XLEN), .JBITS(JBITS)) u_jump (
        .pc_cur (pc),
        .jfield (jump_field),
        .target (jump_tgt)
    );

    pcu_next_sel #(.XLEN(XLEN)) u_sel (
        .src        (pc_src),
        .alu_result (alu_result),
        .alu_buf    (alu_out_reg),
        .jump_tgt   (jump_tgt),
        .pc_cur     (pc),
        .nxt        (pc_next)
    );

    pcu_wr_gate u_gate (
        .wr      (pc_wr),
        .wr_cond (pc_wr_cond),
        .zero    (alu_zero),
        .en      (wr_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (wr_en) begin
            pc <= pc_next;
        end
    end
endmodule

// File: rtl/pc_update_unit_chk.sv
module pc_update_unit_chk #(
    parameter int XLEN  = 32,
    parameter int JBITS = 26
) (
    input logic             clk,
    input logic             rst,
    input logic [XLEN-1:0]  alu_result,
    input logic [XLEN-1:0]  alu_out_reg,
    input logic [JBITS-1:0] jump_field,
    input logic             alu_zero,
    input logic [1:0]       pc_src,
    input logic             pc_wr,
    input logic             pc_wr_cond,
    input logic [XLEN-1:0]  pc
);
    localparam int HI = XLEN - JBITS - 2;

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> pc == '0);

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !(pc_wr_cond && alu_zero)) |=> $stable(pc));

    // R3
    load_alu_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'b00) |=> pc == $past(alu_result));

    // R4
    load_buf_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_cond && alu_zero && pc_src == 2'b01) |=> pc == $past(alu_out_reg));

    // R5
    load_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'b10) |=>
        (pc[XLEN-1 -: HI] == $past(pc[XLEN-1 -: HI]) &&
         pc[XLEN-HI-1:2] == $past(jump_field) && pc[1:0] == 2'b00));

    // R6
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_src == 2'b11) |=> $stable(pc));

    // R7
    not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_cond && !alu_zero && !pc_wr) |=> $stable(pc));

    // R8
    uncond_nozero_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && !alu_zero && pc_src == 2'b01) |=> pc == $past(alu_out_reg));
endmodule

bind pc_update_unit pc_update_unit_chk #(.XLEN(XLEN), .JBITS(JBITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .alu_result  (alu_result),
    .alu_out_reg (alu_out_reg),
    .jump_field  (jump_field),
    .alu_zero    (alu_zero),
    .pc_src      (pc_src),
    .pc_wr       (pc_wr),
    .pc_wr_cond  (pc_wr_cond),
    .pc          (pc)
);

// File: tb/pc_update_unit_bench.sv
`timescale 1ns/1ps
module pc_update_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] alu_result = '0;
    logic [31:0] alu_out_reg = '0;
    logic [25:0] jump_field = '0;
    logic        alu_zero = 1'b0;
    logic [1:0]  pc_src = 2'b00;
    logic        pc_wr = 1'b0;
    logic        pc_wr_cond = 1'b0;
    logic [31:0] pc;

    int unsigned model_pc = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    pc_update_unit u_pc_update_unit (
        .clk         (clk),
        .rst         (rst),
        .alu_result  (alu_result),
        .alu_out_reg (alu_out_reg),
        .jump_field  (jump_field),
        .alu_zero    (alu_zero),
        .pc_src      (pc_src),
        .pc_wr       (pc_wr),
        .pc_wr_cond  (pc_wr_cond),
        .pc          (pc)
    );

    task automatic check(string tag, logic [31:0] act, int unsigned exp);
        n_vec++;
        if (act !== exp[31:0]) begin
            n_bad++;
            $display("FAIL %s: pc=%08h expected %08h", tag, act, exp[31:0]);
        end
    endtask

    task automatic apply(string tag, logic r, logic [31:0] ar, logic [31:0] ao,
                         logic [25:0] jf, logic z, logic [1:0] s, logic w, logic c);
        @(negedge clk);
        rst = r; alu_result = ar; alu_out_reg = ao; jump_field = jf;
        alu_zero = z; pc_src = s; pc_wr = w; pc_wr_cond = c;
        #2;
        // R9: output unchanged between edges
        check("R9", pc, model_pc);
        @(posedge clk);
        if (r) model_pc = 0;
        else if (w || (c && z)) begin
            if (s == 2'd0) model_pc = ar;
            else if (s == 2'd1) model_pc = ao;
            else if (s == 2'd2) model_pc = (model_pc & 32'hF000_0000) | ({6'd0, jf} << 2);
        end
        #2;
        check(tag, pc, model_pc);
    endtask

    initial begin
        @(posedge clk);
        #2;
        model_pc = 0;
        apply("R1", 1, 32'h1234_5678, 32'h9, 26'h1, 1, 2'd0, 1, 1);
        apply("R3", 0, 32'h0000_0004, 0, 0, 0, 2'd0, 1, 0);
        apply("R3", 0, 32'h0000_0008, 0, 0, 1, 2'd0, 1, 0);
        apply("R2", 0, 32'hDEAD_BEEC, 32'h44, 0, 0, 2'd0, 0, 0);
        apply("R4", 0, 0, 32'h0000_0100, 0, 1, 2'd1, 0, 1);
        apply("R7", 0, 32'h50, 32'h0000_0200, 0, 0, 2'd1, 0, 1);
        apply("R8", 0, 0, 32'h0000_0300, 0, 0, 2'd1, 1, 0);
        apply("R3", 0, 32'hA000_0010, 0, 0, 0, 2'd0, 1, 0);
        apply("R5", 0, 0, 0, 26'h3FF_FFFF, 0, 2'd2, 1, 0);
        apply("R5", 0, 0, 0, 26'h000_1235, 1, 2'd2, 0, 1);
        apply("R6", 0, 32'h7777_7770, 32'h8888_8880, 26'h5, 1, 2'd3, 1, 1);
        apply("R2", 0, 32'h1111_1110, 32'h2222_2220, 26'h7, 1, 2'd1, 0, 0);
        apply("R1", 1, 32'h4, 0, 0, 0, 2'd0, 1, 0);
        for (int i = 0; i < 400; i++) begin
            apply("R2", ($urandom_range(0, 49) == 0), $urandom & 32'hFFFF_FFFC,
                  $urandom & 32'hFFFF_FFFC, 26'($urandom), 1'($urandom),
                  2'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule